// File: doc/BRIEF.md
# Write-Through Snooping Line Controller

This block keeps one private, direct-mapped, write-through cache coherent with its peers on a shared snooping bus. Each line holds a tag, one data word and a single presence bit, so a line is either Invalid or Valid. The processor side presents reads and writes. Reads that find a matching Valid line are served locally in the same cycle. Every other request, meaning read misses and all writes, is placed on the bus and holds the processor until the bus grant arrives.

The bus side has two parts. The first drives this cache's own request: command, address, write data and a fixed requester number. The second watches whatever transaction currently owns the bus. When another requester writes an address that this cache holds, the local copy is dropped. Writes never allocate a line. Transactions that carry this cache's own requester number are not treated as snoops. An external arbiter grants the bus to one requester per cycle, and a memory model supplies read data during the grant cycle.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first read of any address is a miss.
- R2: A read miss raises `bus_req` with `bus_cmd` = 2'b01 and holds `cpu_stall` high until `bus_gnt`. In the grant cycle `cpu_stall` is low and `cpu_rdata` equals `bus_rdata`. From the next cycle the line is Valid with that word.
- R3: A read that hits a Valid line with a matching tag raises `cpu_hit`, returns the stored word in the same cycle, keeps `cpu_stall` low and raises no bus request.
- R4: Every write raises `bus_req` with `bus_cmd` = 2'b10, presents its address and data on `bus_addr`/`bus_wdata`, and stalls until grant. A write hit also updates the local word and leaves the line Valid.
- R5: A write miss goes to the bus but allocates nothing. The target line keeps whatever it held before.
- R6: A snooped write (`snoop_cmd` = 2'b10) from another requester that matches a Valid line makes that line Invalid from the next cycle. This cache raises no bus request in response.
- R7: A snooped transaction whose `snoop_id` equals this cache's requester number never invalidates a line.
- R8: A snooped read from another requester changes no line state.
- R9: Addresses are split into index (low bits) and tag. Two addresses with the same index and different tags conflict, and a read miss replaces the line's tag and data.
- R10: When no bus request is raised, `bus_cmd` is 2'b00. `bus_id` always carries the requester number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_stall | output | 1 | Request must be held |
| cpu_hit | output | 1 | Address matches a Valid line |
| cpu_rdata | output | DATA_W | Read data, valid when a read is not stalled |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Bus granted to this cache this cycle |
| bus_cmd | output | 2 | 00 idle, 01 read, 10 write |
| bus_addr | output | ADDR_W | Address of own transaction |
| bus_wdata | output | DATA_W | Write data of own transaction |
| bus_id | output | ID_W | Own requester number |
| bus_rdata | input | DATA_W | Read data returned in the grant cycle |
| snoop_valid | input | 1 | A transaction is on the bus |
| snoop_cmd | input | 2 | Command on the bus |
| snoop_addr | input | ADDR_W | Address on the bus |
| snoop_id | input | ID_W | Requester number on the bus |

## Verification
Hits, stall and bus command are combinational and are due in the cycle the request is presented. Read data on a miss is due in the grant cycle itself. Line state changes from fills, write-hit updates and snoop invalidations take effect at the edge that closes the grant cycle, so they are visible to the next request. The bench therefore drives each request at a falling edge. It samples the outputs shortly after that edge, before the rising edge that would commit the operation. It then judges state changes only through the hit flag and data of later requests.

// File: rtl/wt_coh_pkg.sv
package wt_coh_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10
  } bus_cmd_e;

  // Presence bit update: a snoop kill wins, a fill sets, otherwise hold.
  function automatic logic wt_next_valid(logic cur, logic fill, logic kill);
    if (kill)      return 1'b0;
    else if (fill) return 1'b1;
    else           return cur;
  endfunction

  // Bus command for a processor request.
  function automatic bus_cmd_e wt_bus_cmd(logic req, logic we, logic hit);
    if (!req)    return CMD_IDLE;
    else if (we) return CMD_WR;
    else if (hit) return CMD_IDLE;
    else         return CMD_RD;
  endfunction

endpackage

// File: rtl/wt_line_store.sv
module wt_line_store
  import wt_coh_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cpu_idx,
  output logic              cpu_vld,
  output logic [TAG_W-1:0]  cpu_tag,
  output logic [DATA_W-1:0] cpu_data,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic              snp_vld,
  output logic [TAG_W-1:0]  snp_tag,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              kill_en,
  output logic [LINES-1:0]  valid_vec
);

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_fill, hit_kill;
    assign hit_fill = fill_en && (cpu_idx == IDX_W'(g));
    assign hit_kill = kill_en && (snp_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) valid_vec[g] <= 1'b0;
      else        valid_vec[g] <= wt_next_valid(valid_vec[g], hit_fill, hit_kill);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[cpu_idx]  <= fill_tag;
      data_q[cpu_idx] <= fill_data;
    end else if (wr_en) begin
      data_q[cpu_idx] <= wr_data;
    end
  end

  assign cpu_vld  = valid_vec[cpu_idx];
  assign cpu_tag  = tag_q[cpu_idx];
  assign cpu_data = data_q[cpu_idx];
  assign snp_vld  = valid_vec[snp_idx];
  assign snp_tag  = tag_q[snp_idx];

endmodule

// File: rtl/wt_snoop_filter.sv
module wt_snoop_filter
  import wt_coh_pkg::*;
#(
  parameter int TAG_W = 7,
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input  logic             snoop_valid,
  input  logic [1:0]       snoop_cmd,
  input  logic [ID_W-1:0]  snoop_id,
  input  logic [TAG_W-1:0] snoop_tag,
  input  logic             line_vld,
  input  logic [TAG_W-1:0] line_tag,
  output logic             foreign,
  output logic             kill
);

  assign foreign = snoop_valid && (snoop_id != ID_W'(MY_ID));
  assign kill    = foreign && (bus_cmd_e'(snoop_cmd) == CMD_WR)
                   && line_vld && (line_tag == snoop_tag);

endmodule

// File: rtl/wt_req_ctrl.sv
module wt_req_ctrl
  import wt_coh_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [TAG_W-1:0] cpu_tag,
  input  logic             line_vld,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             bus_gnt,
  output logic             hit,
  output logic             need_bus,
  output logic [1:0]       cmd,
  output logic             stall,
  output logic             fill,
  output logic             wr_hit_upd,
  output logic             wr_miss_done
);

  logic done_bus;

  assign hit          = cpu_req && line_vld && (line_tag == cpu_tag);
  assign need_bus     = cpu_req && (cpu_we || !hit);
  assign cmd          = wt_bus_cmd(cpu_req, cpu_we, hit);
  assign stall        = need_bus && !bus_gnt;
  assign done_bus     = need_bus && bus_gnt;
  assign fill         = done_bus && !cpu_we;
  assign wr_hit_upd   = done_bus && cpu_we && hit;
  assign wr_miss_done = done_bus && cpu_we && !hit;

endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
  import wt_coh_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [ID_W-1:0]   bus_id,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [ID_W-1:0]   snoop_id
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  // Named internal events, observed by the bound checker.
  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tagf, snp_tagf;
  logic              line_vld, snp_vld;
  logic [TAG_W-1:0]  line_tag, snp_line_tag;
  logic [DATA_W-1:0] line_data;
  logic              line_fill, line_wr, wr_miss_done, snoop_kill, snoop_foreign;
  logic [LINES-1:0]  valid_vec;

  assign cpu_idx  = cpu_addr[IDX_W-1:0];
  assign cpu_tagf = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx  = snoop_addr[IDX_W-1:0];
  assign snp_tagf = snoop_addr[ADDR_W-1:IDX_W];

  wt_req_ctrl #(.TAG_W(TAG_W)) u_req (
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_tag      (cpu_tagf),
    .line_vld     (line_vld),
    .line_tag     (line_tag),
    .bus_gnt      (bus_gnt),
    .hit          (cpu_hit),
    .need_bus     (bus_req),
    .cmd          (bus_cmd),
    .stall        (cpu_stall),
    .fill         (line_fill),
    .wr_hit_upd   (line_wr),
    .wr_miss_done (wr_miss_done)
  );

  wt_snoop_filter #(.TAG_W(TAG_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_snp (
    .snoop_valid (snoop_valid),
    .snoop_cmd   (snoop_cmd),
    .snoop_id    (snoop_id),
    .snoop_tag   (snp_tagf),
    .line_vld    (snp_vld),
    .line_tag    (snp_line_tag),
    .foreign     (snoop_foreign),
    .kill        (snoop_kill)
  );

  wt_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_idx   (cpu_idx),
    .cpu_vld   (line_vld),
    .cpu_tag   (line_tag),
    .cpu_data  (line_data),
    .snp_idx   (snp_idx),
    .snp_vld   (snp_vld),
    .snp_tag   (snp_line_tag),
    .fill_en   (line_fill),
    .fill_tag  (cpu_tagf),
    .fill_data (bus_rdata),
    .wr_en     (line_wr),
    .wr_data   (cpu_wdata),
    .kill_en   (snoop_kill),
    .valid_vec (valid_vec)
  );

  assign cpu_rdata = cpu_hit ? line_data : bus_rdata;
  assign bus_addr  = cpu_addr;
  assign bus_wdata = cpu_wdata;
  assign bus_id    = ID_W'(MY_ID);

endmodule

// File: rtl/wt_snoop_ctrl_chk.sv
module wt_snoop_ctrl_chk #(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_we,
  input logic             cpu_hit,
  input logic             cpu_stall,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic [1:0]       bus_cmd,
  input logic             snoop_valid,
  input logic [ID_W-1:0]  snoop_id,
  input logic             snoop_kill,
  input logic             line_fill,
  input logic             wr_miss_done,
  input logic [IDX_W-1:0] cpu_idx,
  input logic [IDX_W-1:0] snp_idx,
  input logic [LINES-1:0] valid_vec
);

  p_stall_until_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |-> cpu_stall);

  p_fill_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_fill |=> valid_vec[$past(cpu_idx)]);

  p_hit_read_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_hit) |-> (!bus_req && !cpu_stall));

  p_write_on_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we) |-> (bus_req && bus_cmd == 2'b10));

  p_write_miss_no_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_miss_done && !valid_vec[cpu_idx]) |=> !valid_vec[$past(cpu_idx)]);

  p_snoop_invalidates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_kill |=> !valid_vec[$past(snp_idx)]);

  p_own_id_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_id == ID_W'(MY_ID)) |-> !snoop_kill);

  p_idle_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (bus_cmd == 2'b00));

endmodule

bind wt_snoop_ctrl wt_snoop_ctrl_chk #(
  .LINES(LINES), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_hit      (cpu_hit),
  .cpu_stall    (cpu_stall),
  .bus_req      (bus_req),
  .bus_gnt      (bus_gnt),
  .bus_cmd      (bus_cmd),
  .snoop_valid  (snoop_valid),
  .snoop_id     (snoop_id),
  .snoop_kill   (snoop_kill),
  .line_fill    (line_fill),
  .wr_miss_done (wr_miss_done),
  .cpu_idx      (cpu_idx),
  .snp_idx      (snp_idx),
  .valid_vec    (valid_vec)
);

// File: tb/wt_snoop_ctrl_bench.sv
module wt_snoop_ctrl_bench;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NL = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]    req, we, stall, hit, breq, gnt, en;
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [1:0]    bcmd [2];
  logic [AW-1:0] baddr [2];
  logic [DW-1:0] bwdata [2];
  logic [IW-1:0] bid [2];

  logic          s_valid;
  logic [1:0]    s_cmd;
  logic [AW-1:0] s_addr;
  logic [IW-1:0] s_id;
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] b_rdata;

  // Fixed-priority arbiter and shared bus.
  assign gnt[0] = breq[0] && en[0];
  assign gnt[1] = breq[1] && en[1] && !gnt[0];
  assign s_valid = |gnt;
  assign s_cmd   = gnt[0] ? bcmd[0]  : gnt[1] ? bcmd[1]  : 2'b00;
  assign s_addr  = gnt[0] ? baddr[0] : baddr[1];
  assign s_id    = gnt[0] ? bid[0]   : bid[1];
  assign b_rdata = mem[s_addr];

  for (genvar i = 0; i < 2; i++) begin : g_c
    wt_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .ID_W(IW), .MY_ID(i)) u_wt_snoop_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(req[i]), .cpu_we(we[i]), .cpu_addr(addr[i]), .cpu_wdata(wdata[i]),
      .cpu_stall(stall[i]), .cpu_hit(hit[i]), .cpu_rdata(rdata[i]),
      .bus_req(breq[i]), .bus_gnt(gnt[i]), .bus_cmd(bcmd[i]), .bus_addr(baddr[i]),
      .bus_wdata(bwdata[i]), .bus_id(bid[i]), .bus_rdata(b_rdata),
      .snoop_valid(s_valid), .snoop_cmd(s_cmd), .snoop_addr(s_addr), .snoop_id(s_id)
    );
  end

  // Reference model of both caches.
  bit          mv [2][NL];
  int          mt [2][NL];
  logic [DW-1:0] md [2][NL];

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit model_hit(int c, int a);
    return mv[c][a % NL] && (mt[c][a % NL] == a / NL);
  endfunction

  task automatic do_op(int c, bit w, int a, logic [DW-1:0] d, string r);
    int o = 1 - c;
    int ix = a % NL;
    bit eh = model_hit(c, a);
    @(negedge clk);
    req[c] = 1'b1; we[c] = w; addr[c] = AW'(a); wdata[c] = d; en = 2'b00;
    #2;
    check({r, " hit"}, DW'(hit[c]), DW'(eh));
    check({r, " other idle"}, DW'(breq[o]), 0);
    if (!w && eh) begin
      check({r, " stall"}, DW'(stall[c]), 0);
      check({r, " no bus"}, DW'(breq[c]), 0);
      check({r, " cmd"}, DW'(bcmd[c]), 0);
      check({r, " data"}, rdata[c], md[c][ix]);
    end else begin
      check({r, " stall"}, DW'(stall[c]), 1);
      check({r, " bus req"}, DW'(breq[c]), 1);
      check({r, " cmd"}, DW'(bcmd[c]), w ? 32'd2 : 32'd1);
      @(negedge clk);
      en[c] = 1'b1;
      #2;
      check({r, " stall at gnt"}, DW'(stall[c]), 0);
      check({r, " addr"}, DW'(baddr[c]), DW'(a));
      if (w) check({r, " wdata"}, bwdata[c], d);
      else   check({r, " fill data"}, rdata[c], mem[a]);
      if (w) begin
        mem[a] = d;
        if (eh) md[c][ix] = d;
        if (model_hit(o, a)) mv[o][ix] = 1'b0;
      end else begin
        mv[c][ix] = 1'b1; mt[c][ix] = a / NL; md[c][ix] = mem[a];
      end
    end
    @(negedge clk);
    req[c] = 1'b0; en = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'h1000_0000 + i * 7;
    for (int c = 0; c < 2; c++)
      for (int l = 0; l < NL; l++) begin mv[c][l] = 0; mt[c][l] = 0; md[c][l] = '0; end
    req = '0; we = '0; en = '0;
    for (int c = 0; c < 2; c++) begin addr[c] = '0; wdata[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    // R1 / R10: idle after reset
    check("R10 idle cmd c0", DW'(bcmd[0]), 0);
    check("R10 id c1", DW'(bid[1]), 1);
    check("R1 no stall", DW'(stall), 0);

    do_op(0, 0, 5, '0, "R1 first read misses");
    do_op(0, 0, 5, '0, "R3 read hit");
    do_op(0, 1, 5, 32'hCAFE_0001, "R4 write hit");
    do_op(0, 0, 5, '0, "R7 own write keeps line");
    do_op(1, 0, 5, '0, "R2 peer read miss");
    do_op(0, 0, 5, '0, "R8 snooped read no effect");
    do_op(1, 1, 5, 32'hBEEF_0002, "R6 peer write");
    do_op(0, 0, 5, '0, "R6 line was invalidated");
    do_op(0, 1, 13, 32'h1234_5678, "R5 write miss");
    do_op(0, 0, 5, '0, "R5 old line kept");
    do_op(0, 0, 13, '0, "R9 conflict read miss");
    do_op(0, 0, 5, '0, "R9 replaced line misses");
    do_op(1, 1, 21, 32'h0000_00AA, "R5 write miss c1");
    do_op(1, 0, 21, '0, "R5 no alloc c1");

    for (int k = 0; k < 400; k++) begin
      int c = int'($urandom_range(1, 0));
      bit w = bit'($urandom_range(1, 0));
      int a = int'($urandom_range(31, 0));
      do_op(c, w, a, $urandom(), "RND");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule